// File: doc/BRIEF.md
# Pin Expander Target on a Two-Wire Serial Bus

This block is a target on a standard I2C bus that gives a host up to eight general-purpose pins. The kind of each pin is fixed when the block is built. A pin can be a push-pull output, an input that is never driven, or an open-drain pin that can serve as input or output. The host has no registers to address. Each write transfer updates the output latch, and each read transfer returns the pin levels. An optional second byte carries extra data in each direction.

A pin that can act as an input passes through a two-flop synchronizer and then a change detector. The detector records every level change in a sticky transition flag. When a set flag is enabled by the interrupt mask, the active-low interrupt line goes low. A two-byte read returns the levels and then the flags. When the host acknowledges the flag byte, the flags it reported are cleared. A change that arrives after the flag byte was captured stays pending. When the independent-mask option is built in, the second byte of a write loads the per-pin interrupt enable mask. The pads are modelled as separate input, output and output-enable vectors. The bus data line is modelled the same way: an input and a pull-down enable.

Top module: `pinx_expander`

## Requirements
- R1: The block acknowledges only the 7-bit address whose upper three bits equal ADDR_HI (default 110) and whose lower four bits equal `strap_addr`. Bit 0 of the address byte selects the direction (1 means read). For any other address it leaves SDA released and ignores the whole transfer.
- R2: Each pin's 2-bit kind in KINDS (pin i at bits 2i+1:2i) sets its pad. Kind 01 (push-pull) drives `pin_out` from the latch with `pin_oe` = 1. Kind 10 (input only) has `pin_oe` = 0 and `pin_out` = 0. Kind 11 (open-drain) has `pin_out` = 0 and `pin_oe` = NOT latch, so a latch value of 1 releases the pin.
- R3: After reset the output latch is all ones. The first data byte of a write transfer replaces the latch, and nothing else changes it.
- R4: The first byte of a read, and every even-numbered byte after it, returns the pin levels. A push-pull pin reports its latch bit. Every other pin reports its synchronized pad input.
- R5: A level change on an input-only or open-drain pin sets that pin's transition flag. A push-pull pin never sets a flag.
- R6: The second byte of a read, and every odd-numbered byte after it, returns the transition flags. When the host acknowledges that byte, exactly the flags it reported are cleared. A change detected after the byte was captured stays set.
- R7: `irq_n` is low exactly when some flag is set and its mask bit is 1. Otherwise it is high, including after reset.
- R8: With IND_MASK = 1, the second data byte of a write loads the interrupt mask, which resets to all zeros. Data bytes after the second are acknowledged and have no effect on the latch or the mask.
- R9: If the host does not acknowledge the flag byte, no flag is cleared.
- R10: After reset, SDA is released and no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL and SDA are oversampled with it |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| strap_addr | input | 4 | Low four bits of the target address |
| pin_in | input | N | Pad input levels |
| pin_out | output | N | Pad output values |
| pin_oe | output | N | Pad output enables |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is a pin that changes between the moment the flag byte is captured and the moment the host acknowledges it. That change must survive the clear, even though the host never saw it. The bench reaches this case with a read task that flips the external level of one pin in the middle of the flag byte. It then checks three things: the captured byte lacks that bit, the bit remains pending afterwards, and enabling its mask pulls the interrupt low. Open-drain feedback is also modelled at the pads, so writing 0 to an open-drain pin creates a real level change that must raise a flag.

// File: rtl/pinx_pkg.sv
package pinx_pkg;
  localparam logic [1:0] KIND_PP = 2'b01;
  localparam logic [1:0] KIND_IN = 2'b10;
  localparam logic [1:0] KIND_OD = 2'b11;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_ADDR,
    BUS_ADDR_ACK,
    BUS_WR,
    BUS_WR_ACK,
    BUS_RD,
    BUS_RD_ACK
  } bus_state_t;
endpackage

// File: rtl/pinx_bus_sync.sv
module pinx_bus_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_m, scl_q, scl_d;
  logic sda_m, sda_q, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_m <= 1'b1; scl_q <= 1'b1; scl_d <= 1'b1;
      sda_m <= 1'b1; sda_q <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_q <= scl_m; scl_d <= scl_q;
      sda_m <= sda_i; sda_q <= sda_m; sda_d <= sda_q;
    end
  end

  assign sda_s     = sda_q;
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  // data edges only count as bus conditions while the clock is steadily high
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/pinx_change_det.sv
module pinx_change_det #(
  parameter int N = 8,
  parameter logic [N-1:0] INCAP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_in,
  input  logic         clr_en,
  input  logic [N-1:0] clr_bits,
  input  logic [N-1:0] mask_eff,
  output logic [N-1:0] level_s,
  output logic [N-1:0] flags_q,
  output logic         irq_n
);
  logic [N-1:0] meta_q, sync_q, prev_q;
  logic [2:0]   warm_q;
  logic [N-1:0] change, flags_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
      warm_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
      warm_q <= {warm_q[1:0], 1'b1};
    end
  end

  // edges are trusted only once the previous sample holds a real pin value
  assign change  = warm_q[2] ? ((sync_q ^ prev_q) & INCAP) : '0;
  assign flags_n = (flags_q & ~(clr_en ? clr_bits : '0)) | change;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_n   <= 1'b1;
    end else begin
      flags_q <= flags_n;
      irq_n   <= ~|(flags_n & mask_eff);
    end
  end

  assign level_s = sync_q;
endmodule

// File: rtl/pinx_byte_engine.sv
module pinx_byte_engine
  import pinx_pkg::*;
#(
  parameter logic [2:0] ADDR_HI  = 3'b110,
  parameter bit         IND_MASK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [3:0]        strap_addr,
  input  logic [BYTE_W-1:0] rd_level,
  input  logic [BYTE_W-1:0] rd_flags,
  output logic              sda_oe,
  output logic              wr_latch_en,
  output logic              wr_mask_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              clr_en,
  output logic [BYTE_W-1:0] clr_bits
);
  bus_state_t        state_q;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, cap_q;
  logic              rw_q, mack_q;
  logic [1:0]        idx_q;

  assign clr_bits = cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= BUS_IDLE;
      bit_cnt     <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      cap_q       <= '0;
      rw_q        <= 1'b0;
      mack_q      <= 1'b0;
      idx_q       <= '0;
      sda_oe      <= 1'b0;
      wr_latch_en <= 1'b0;
      wr_mask_en  <= 1'b0;
      wr_data     <= '0;
      clr_en      <= 1'b0;
    end else begin
      wr_latch_en <= 1'b0;
      wr_mask_en  <= 1'b0;
      clr_en      <= 1'b0;
      if (start_det) begin
        state_q <= BUS_ADDR;
        bit_cnt <= '0;
        idx_q   <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state_q <= BUS_IDLE;
        sda_oe  <= 1'b0;
      end else begin
        case (state_q)
          BUS_ADDR: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (rx_sh[7:1] == {ADDR_HI, strap_addr}) begin
                sda_oe  <= 1'b1;
                rw_q    <= rx_sh[0];
                state_q <= BUS_ADDR_ACK;
              end else begin
                state_q <= BUS_IDLE;
              end
            end
          end
          BUS_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_q) begin
                tx_sh   <= rd_level;
                sda_oe  <= ~rd_level[7];
                state_q <= BUS_RD;
              end else begin
                sda_oe  <= 1'b0;
                state_q <= BUS_WR;
              end
            end
          end
          BUS_WR: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              sda_oe  <= 1'b1;
              wr_data <= rx_sh;
              if (idx_q == 2'd0) wr_latch_en <= 1'b1;
              if (idx_q == 2'd1 && IND_MASK) wr_mask_en <= 1'b1;
              if (idx_q != 2'd2) idx_q <= idx_q + 2'd1;
              state_q <= BUS_WR_ACK;
            end
          end
          BUS_WR_ACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state_q <= BUS_WR;
            end
          end
          BUS_RD: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe  <= 1'b0;
                state_q <= BUS_RD_ACK;
              end else begin
                sda_oe <= ~tx_sh[6];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
              end
            end
          end
          BUS_RD_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
              if (~sda_s && idx_q[0]) clr_en <= 1'b1;
            end else if (scl_fall) begin
              if (mack_q) begin
                idx_q   <= {1'b0, ~idx_q[0]};
                bit_cnt <= '0;
                state_q <= BUS_RD;
                if (!idx_q[0]) begin
                  tx_sh  <= rd_flags;
                  cap_q  <= rd_flags;
                  sda_oe <= ~rd_flags[7];
                end else begin
                  tx_sh  <= rd_level;
                  sda_oe <= ~rd_level[7];
                end
              end else begin
                state_q <= BUS_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pinx_expander.sv
module pinx_expander
  import pinx_pkg::*;
#(
  parameter int             N        = 8,
  parameter logic [2*N-1:0] KINDS    = 16'h5FF5,
  parameter logic [2:0]     ADDR_HI  = 3'b110,
  parameter bit             IND_MASK = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         scl_i,
  input  logic         sda_i,
  output logic         sda_oe,
  input  logic [3:0]   strap_addr,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe,
  output logic         irq_n
);
  function automatic logic [N-1:0] kind_mask(input logic [1:0] k);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (KINDS[2*i +: 2] == k);
    return m;
  endfunction

  localparam logic [N-1:0] PPM   = kind_mask(KIND_PP);
  localparam logic [N-1:0] INM   = kind_mask(KIND_IN);
  localparam logic [N-1:0] ODM   = kind_mask(KIND_OD);
  localparam logic [N-1:0] INCAP = INM | ODM;

  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_latch_en, wr_mask_en, clr_en;
  logic [BYTE_W-1:0] wr_data, clr_bits, rd_level, rd_flags;
  logic [N-1:0]      lat_q, mask_q, mask_eff, level_s, flags_q;

  pinx_bus_sync u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  pinx_byte_engine #(.ADDR_HI(ADDR_HI), .IND_MASK(IND_MASK)) u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .strap_addr(strap_addr),
    .rd_level(rd_level), .rd_flags(rd_flags), .sda_oe(sda_oe),
    .wr_latch_en(wr_latch_en), .wr_mask_en(wr_mask_en), .wr_data(wr_data),
    .clr_en(clr_en), .clr_bits(clr_bits)
  );

  pinx_change_det #(.N(N), .INCAP(INCAP)) u_det (
    .clk(clk), .rst(rst), .pin_in(pin_in), .clr_en(clr_en),
    .clr_bits(clr_bits[N-1:0]), .mask_eff(mask_eff),
    .level_s(level_s), .flags_q(flags_q), .irq_n(irq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= '1;
      mask_q <= '0;
    end else begin
      if (wr_latch_en) lat_q  <= wr_data[N-1:0];
      if (wr_mask_en)  mask_q <= wr_data[N-1:0];
    end
  end

  assign mask_eff = IND_MASK ? mask_q : '1;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_byte
    if (i < N) begin : g_used
      assign rd_level[i] = PPM[i] ? lat_q[i] : level_s[i];
      assign rd_flags[i] = flags_q[i];
    end else begin : g_pad
      assign rd_level[i] = 1'b0;
      assign rd_flags[i] = 1'b0;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    if (KINDS[2*i +: 2] == KIND_PP) begin : g_pp
      assign pin_out[i] = lat_q[i];
      assign pin_oe[i]  = 1'b1;
    end else if (KINDS[2*i +: 2] == KIND_OD) begin : g_od
      assign pin_out[i] = 1'b0;
      assign pin_oe[i]  = ~lat_q[i];
    end else begin : g_in
      assign pin_out[i] = 1'b0;
      assign pin_oe[i]  = 1'b0;
    end
  end
endmodule

// File: rtl/pinx_checker.sv
module pinx_checker #(
  parameter int           N        = 8,
  parameter logic [N-1:0] PPM      = '0,
  parameter logic [N-1:0] INM      = '0,
  parameter logic [N-1:0] ODM      = '0,
  parameter bit           IND_MASK = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic         sda_oe,
  input logic         irq_n,
  input logic [N-1:0] pin_out,
  input logic [N-1:0] pin_oe,
  input logic [N-1:0] lat_q,
  input logic [N-1:0] mask_eff,
  input logic [N-1:0] flags_q,
  input logic         wr_latch_en
);
  localparam logic [N-1:0] MASK_RST = IND_MASK ? '0 : '1;

  p_reset_state_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sda_oe && irq_n && lat_q == '1 && mask_eff == MASK_RST));

  p_pushpull_pad_r2: assert property (@(posedge clk) disable iff (rst)
    ((pin_oe & PPM) == PPM) && (((pin_out ^ lat_q) & PPM) == '0));

  p_input_float_r2: assert property (@(posedge clk) disable iff (rst)
    ((pin_oe & INM) == '0) && ((pin_out & INM) == '0));

  p_opendrain_pad_r2: assert property (@(posedge clk) disable iff (rst)
    ((pin_out & ODM) == '0) && (((pin_oe & lat_q) & ODM) == '0));

  p_latch_only_on_write_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(lat_q) |-> $past(wr_latch_en));

  p_no_outonly_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (flags_q & PPM) == '0);

  p_irq_has_cause_r7: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> |(flags_q & mask_eff));
endmodule

bind pinx_expander pinx_checker #(
  .N(N), .PPM(PPM), .INM(INM), .ODM(ODM), .IND_MASK(IND_MASK)
) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .irq_n(irq_n),
  .pin_out(pin_out), .pin_oe(pin_oe), .lat_q(lat_q),
  .mask_eff(mask_eff), .flags_q(flags_q), .wr_latch_en(wr_latch_en)
);

// File: tb/test_pinx_expander.sv
module test_pinx_expander;
  localparam int CLK_PERIOD = 10;
  localparam int H = 12;
  localparam logic [15:0] KINDS_T = 16'h5FA5;
  localparam logic [7:0] PPM = 8'hC3, ODM = 8'h30, INM = 8'h0C;
  localparam logic [7:0] INCAP = 8'h3C;
  localparam logic [6:0] ME = 7'h6A;

  logic clk = 1'b0, rst = 1'b1;
  logic m_scl = 1'b1, m_low = 1'b0;
  logic sda_oe, sda_line, irq_n;
  logic [3:0] strap = 4'hA;
  logic [7:0] ext = 8'hFF;
  logic [7:0] pin_in, pin_out, pin_oe;

  logic [7:0] mlat = 8'hFF, mmask = 8'h00, mflags = 8'h00;
  logic quiet = 1'b0;
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = ~(m_low | sda_oe);
  assign pin_in = ext & ~(pin_oe & ODM);

  pinx_expander #(.N(8), .KINDS(KINDS_T), .ADDR_HI(3'b110), .IND_MASK(1'b1)) i_pinx_expander (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_addr(strap), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_n(irq_n)
  );

  function automatic logic [7:0] lvl(input logic [7:0] l, input logic [7:0] e);
    return (l & PPM) | (e & INM) | (e & l & ODM);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_lat(input logic [7:0] v);
    logic [7:0] old = lvl(mlat, ext);
    mlat = v;
    mflags = mflags | ((old ^ lvl(mlat, ext)) & INCAP);
  endtask

  task automatic set_ext(input logic [7:0] v);
    logic [7:0] old = lvl(mlat, ext);
    ext = v;
    mflags = mflags | ((old ^ lvl(mlat, ext)) & INCAP);
  endtask

  // reference comparison on every clock while the bus is idle and settled
  always @(negedge clk) begin
    if (quiet && !rst) begin
      chk("R2 pin_out", pin_out, mlat & PPM);
      chk("R2 pin_oe", pin_oe, PPM | (~mlat & ODM));
      chk("R7 irq_n", irq_n, ~|(mflags & mmask));
      chk("R10 sda idle", sda_oe, 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk); m_low = ~b; wq(H); m_scl = 1'b1; wq(H); m_scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    @(negedge clk); m_low = 1'b0; wq(H); m_scl = 1'b1; wq(H/2); b = sda_line;
    wq(H - H/2); m_scl = 1'b0;
  endtask

  task automatic bus_start();
    quiet = 1'b0;
    m_low = 1'b0; m_scl = 1'b1; wq(H); m_low = 1'b1; wq(H); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    @(negedge clk); m_low = 1'b1; wq(H); m_scl = 1'b1; wq(H); m_low = 1'b0; wq(H);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic settle();
    wq(12); quiet = 1'b1; wq(4);
  endtask

  task automatic wr(input logic [6:0] adr, input int n, input logic [7:0] b0,
                    input logic [7:0] b1, input logic [7:0] b2, output logic aack);
    logic a;
    bus_start();
    send_byte({adr, 1'b0}, aack);
    send_byte(b0, a);
    if (n > 1) send_byte(b1, a);
    if (n > 2) send_byte(b2, a);
    bus_stop();
  endtask

  // reads n bytes, acks all but the last; poke flips ext bits mid flag byte
  task automatic rd(input logic [6:0] adr, input int n, input logic [7:0] poke,
                    output logic [7:0] r0, output logic [7:0] r1,
                    output logic [7:0] r2, output logic aack);
    logic [7:0] d;
    logic b;
    r0 = 0; r1 = 0; r2 = 0;
    bus_start();
    send_byte({adr, 1'b1}, aack);
    for (int k = 0; k < n; k++) begin
      for (int i = 7; i >= 0; i--) begin
        if (k == 1 && i == 4 && poke != 0) set_ext(ext ^ poke);
        get_bit(b);
        d[i] = b;
      end
      put_bit(k == n - 1);
      if (k == 0) r0 = d;
      if (k == 1) r1 = d;
      if (k == 2) r2 = d;
    end
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] r0, r1, r2, rep;
    wq(5); rst = 1'b0; wq(6);
    chk("R10 reset irq_n", irq_n, 1);
    chk("R10 reset sda", sda_oe, 0);
    chk("R3 reset latch pads out", pin_out, 8'hC3);
    chk("R2 reset pads oe", pin_oe, 8'hC3);
    quiet = 1'b1; wq(4);

    rd(ME, 1, 0, r0, r1, r2, ack);
    chk("R1 own address ack", ack, 1);
    chk("R4 levels after reset", r0, 8'hFF);
    settle();

    wr(7'h5A, 1, 8'h00, 0, 0, ack);
    chk("R1 foreign address nack", ack, 0);
    settle();
    chk("R1 foreign write ignored", pin_out, 8'hC3);

    wr(ME, 1, 8'h0F, 0, 0, ack);
    set_lat(8'h0F); settle();
    chk("R3 latch loaded", pin_out, 8'h03);
    chk("R2 open-drain pulled", pin_oe, 8'hF3);
    chk("R7 masked flags keep irq high", irq_n, 1);
    rd(ME, 1, 0, r0, r1, r2, ack);
    chk("R4 pushpull reads latch", r0, 8'h0F);
    settle();

    wr(ME, 2, 8'h0F, 8'h30, 0, ack);
    mmask = 8'h30; settle();
    chk("R8 mask enables irq", irq_n, 0);

    rep = mflags;
    rd(ME, 3, 0, r0, r1, r2, ack);
    mflags = mflags & ~rep; settle();
    chk("R6 level byte", r0, 8'h0F);
    chk("R6 flag byte", r1, 8'h30);
    chk("R6 third byte is levels", r2, 8'h0F);
    chk("R6 ack clears irq", irq_n, 1);

    set_ext(8'hFB); settle();
    chk("R5 input pin change masked off", irq_n, 1);
    rd(ME, 2, 0, r0, r1, r2, ack);
    settle();
    chk("R9 nack flag byte value", r1, 8'h04);
    rep = mflags;
    rd(ME, 3, 0, r0, r1, r2, ack);
    mflags = mflags & ~rep; settle();
    chk("R9 flags kept after nack", r1, 8'h04);
    chk("R4 input pin level", r0, 8'h0B);

    wr(ME, 1, 8'h30, 0, 0, ack);
    set_lat(8'h30); settle();
    chk("R5 release raises od flags", irq_n, 0);
    rep = mflags;
    rd(ME, 3, 0, r0, r1, r2, ack);
    mflags = mflags & ~rep; settle();
    chk("R5 pushpull never flags", r1, 8'h30);

    rep = mflags;
    rd(ME, 3, 8'h08, r0, r1, r2, ack);
    mflags = mflags & ~rep; settle();
    chk("R6 captured byte before change", r1, 8'h00);
    chk("R4 level after change", r2, 8'h30);
    wr(ME, 2, 8'h30, 8'h08, 0, ack);
    mmask = 8'h08; settle();
    chk("R6 late change still pending", irq_n, 0);

    wr(ME, 3, 8'h30, 8'h08, 8'hFF, ack);
    settle();
    chk("R8 third byte ignored", irq_n, 0);
    rep = mflags;
    rd(ME, 3, 0, r0, r1, r2, ack);
    mflags = mflags & ~rep; settle();
    chk("R6 late change reported", r1, 8'h08);
    chk("R7 irq released", irq_n, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule